// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem-status portion of a UART. Four active-low modem inputs come in from the pins: clear-to-send, data-set-ready, ring indicator and carrier detect. Each passes through a multi-flop synchronizer. The block keeps an active-high copy of each level and a sticky change flag for each line. Both are returned as one byte to the CPU. A single read strobe clears the flags. While any flag is set, the block requests a modem-status interrupt.

In loopback mode, the four level bits are taken from four modem-control outputs (request-to-send, data-terminal-ready, user output 1 and user output 2) instead of the pins. The change flags are then computed from those bits. The block also drives a transmit-permit output for automatic CTS flow control. That output is re-evaluated only when the transmitter reports a character boundary, so a frame already in progress is never cut short.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 8'h00, `irq` is low and `tx_permit` is high, provided all four pins are held high (inactive).
- R2: In normal mode, a level change in either direction on `cts_n`, `dsr_n` or `dcd_n` sets `rd_data` bit 0, 1 or 3 respectively. The flag appears SYNC_STAGES+1 clock edges after the pin changes.
- R3: Ring flag `rd_data[2]` sets only when the ring level drops from active to inactive, that is when `ri_n` goes 0 to 1. A 1 to 0 transition of `ri_n` leaves it unchanged.
- R4: A cycle with `rd_stb` high clears flags 3:0 at the next edge. A change event that is detected in that same cycle still sets its flag.
- R5: `irq` is high exactly when any of `rd_data[3:0]` is set.
- R6: In normal mode, `rd_data[7:4]` hold the inverted synchronized CTS, DSR, RI and CD pins, from bit 4 upward. They lag the pins by SYNC_STAGES+1 edges.
- R7: With `loopback` high, `rd_data[7:4]` follow `mcr_rts`, `mcr_dtr`, `mcr_out1` and `mcr_out2` one edge later. The pins then have no effect, and the flags are computed from these four bits.
- R8: `tx_permit` changes only on an edge where `tx_boundary` is high. At such an edge it becomes the CTS level bit (`rd_data[4]`) when `autocts_en` is high, and 1 otherwise.
- R9: Without a read, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| loopback | input | 1 | Selects modem-control bits as level source |
| mcr_rts | input | 1 | Request-to-send control bit |
| mcr_dtr | input | 1 | Data-terminal-ready control bit |
| mcr_out1 | input | 1 | User output 1 control bit |
| mcr_out2 | input | 1 | User output 2 control bit |
| rd_stb | input | 1 | CPU read strobe; clears change flags |
| rd_data | output | 8 | {levels[3:0], flags[3:0]} |
| irq | output | 1 | Modem-status interrupt request |
| autocts_en | input | 1 | Enables automatic CTS flow control |
| tx_boundary | input | 1 | Transmitter is idle or about to load a character |
| tx_permit | output | 1 | Transmitter may start the next character |

## Verification
The bench builds the block with SYNC_STAGES set to 2, the default. This makes the pin-to-register latency exactly three edges, which its cycle model tracks. Random pin activity, random reads and mode switches bring within reach events that land in the same cycle as a read, ring transitions in both directions, and flags raised by switching into or out of loopback. Directed sequences pin down the ring direction rule, a coincident event and read in loopback, pin activity ignored in loopback, and a permit held high across a mid-frame CTS drop.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned LINES   = 4;
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_CD  = 3;
  localparam int unsigned RD_W    = 2 * LINES;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msr_rst_sync.sv
module msr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned      WIDTH   = 4,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/msr_tx_gate.sv
module msr_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic enable,
  input  logic cts_level,
  output logic permit
);
  logic permit_q;
  logic permit_d;

  always_comb begin
    permit_d = permit_q;
    if (boundary) permit_d = !enable || cts_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) permit_q <= 1'b1;
    else        permit_q <= permit_d;
  end

  assign permit = permit_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cts_n,
  input  logic            dsr_n,
  input  logic            ri_n,
  input  logic            dcd_n,
  input  logic            loopback,
  input  logic            mcr_rts,
  input  logic            mcr_dtr,
  input  logic            mcr_out1,
  input  logic            mcr_out2,
  input  logic            rd_stb,
  output logic [RD_W-1:0] rd_data,
  output logic            irq,
  input  logic            autocts_en,
  input  logic            tx_boundary,
  output logic            tx_permit
);
  logic      rst_q_n;
  line_vec_t pin_raw_n;
  line_vec_t pin_sync_n;
  line_vec_t mcr_vec;
  line_vec_t src_lvl;
  line_vec_t evt;
  line_vec_t lvl_q, lvl_d;
  line_vec_t flag_q, flag_d;

  msr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  assign pin_raw_n = {dcd_n, ri_n, dsr_n, cts_n};
  assign mcr_vec   = {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL({LINES{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(pin_raw_n), .q(pin_sync_n)
  );

  always_comb begin
    src_lvl = loopback ? mcr_vec : ~pin_sync_n;
    evt     = src_lvl ^ lvl_q;
    evt[IDX_RI] = lvl_q[IDX_RI] & ~src_lvl[IDX_RI];
    lvl_d   = src_lvl;
    flag_d  = (flag_q & {LINES{~rd_stb}}) | evt;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
    end
  end

  msr_tx_gate u_gate (
    .clk(clk), .rst_n(rst_q_n), .boundary(tx_boundary),
    .enable(autocts_en), .cts_level(lvl_q[IDX_CTS]), .permit(tx_permit)
  );

  assign rd_data = {lvl_q, flag_q};
  assign irq     = |flag_q;
endmodule

// File: rtl/msr_checker.sv
module msr_checker
  import msr_pkg::*;
(
  input logic            clk,
  input logic            rst_q_n,
  input logic            rd_stb,
  input logic [RD_W-1:0] rd_data,
  input logic            irq,
  input line_vec_t       evt,
  input logic            loopback,
  input line_vec_t       mcr_vec,
  input logic            tx_boundary,
  input logic            tx_permit
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    evt[IDX_CTS] |=> rd_data[IDX_CTS]);

  assert_ring_trailing_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rd_data[IDX_RI]) |-> $fell(rd_data[LINES+IDX_RI]));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_stb && evt == '0) |=> rd_data[LINES-1:0] == '0);

  assert_irq_any_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq == (rd_data[LINES-1:0] != '0));

  assert_loop_levels_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    loopback |=> rd_data[RD_W-1:LINES] == $past(mcr_vec));

  assert_permit_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !tx_boundary |=> $stable(tx_permit));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_stb |=> (rd_data[LINES-1:0] & $past(rd_data[LINES-1:0])) == $past(rd_data[LINES-1:0]));
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq),
  .evt(evt), .loopback(loopback), .mcr_vec(mcr_vec),
  .tx_boundary(tx_boundary), .tx_permit(tx_permit)
);

// File: tb/modem_status_reg_bench.sv
`timescale 1ns/1ps
module modem_status_reg_bench;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cts_n, dsr_n, ri_n, dcd_n;
  logic loopback, mcr_rts, mcr_dtr, mcr_out1, mcr_out2;
  logic rd_stb, autocts_en, tx_boundary;
  logic [7:0] rd_data;
  logic irq, tx_permit;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_status_reg #(.SYNC_STAGES(STG)) u_modem_status_reg (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .loopback(loopback), .mcr_rts(mcr_rts), .mcr_dtr(mcr_dtr), .mcr_out1(mcr_out1),
    .mcr_out2(mcr_out2), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq),
    .autocts_en(autocts_en), .tx_boundary(tx_boundary), .tx_permit(tx_permit)
  );

  // Reference state derived from the requirements
  logic [3:0] m_pipe [STG];
  logic [3:0] m_lvl, m_flag;
  logic       m_permit;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [3:0] src, ev;
    src = loopback ? {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} : ~m_pipe[STG-1];
    ev  = src ^ m_lvl;
    ev[2] = m_lvl[2] & ~src[2];
    if (tx_boundary) m_permit = !autocts_en || m_lvl[0];
    m_flag = (rd_stb ? 4'b0 : m_flag) | ev;
    m_lvl  = src;
    for (int s = STG-1; s > 0; s--) m_pipe[s] = m_pipe[s-1];
    m_pipe[0] = {dcd_n, ri_n, dsr_n, cts_n};
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(loopback ? "R7 levels" : "R6 levels", {4'b0, rd_data[7:4]}, {4'b0, m_lvl});
    chk("R2 flags", {4'b0, rd_data[3:0]}, {4'b0, m_flag});
    chk("R5 irq", {7'b0, irq}, {7'b0, |m_flag});
    chk("R8 permit", {7'b0, tx_permit}, {7'b0, m_permit});
  endtask

  task automatic cycn(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    {cts_n, dsr_n, ri_n, dcd_n} = 4'hF;
    {loopback, mcr_rts, mcr_dtr, mcr_out1, mcr_out2} = '0;
    {rd_stb, autocts_en, tx_boundary} = '0;
    for (int s = 0; s < STG; s++) m_pipe[s] = 4'hF;
    m_lvl = '0; m_flag = '0; m_permit = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 permit", {7'b0, tx_permit}, 8'h01);

    // R3: leading edge of ring ignored, trailing edge flags
    ri_n = 1'b0; cycn(STG + 2);
    chk("R3 leading edge ignored", rd_data, 8'h40);
    ri_n = 1'b1; cycn(STG + 2);
    chk("R3 trailing edge", rd_data, 8'h04);

    // R9: sticky without read
    cycn(5);
    chk("R9 sticky", rd_data, 8'h04);

    // R4: read clears
    rd_stb = 1'b1; cyc(); rd_stb = 1'b0; cyc();
    chk("R4 read clears", rd_data, 8'h00);

    // R4 coincident event with read, in loopback (R7)
    loopback = 1'b1; cycn(3);
    mcr_rts = 1'b1; rd_stb = 1'b1; cyc();
    rd_stb = 1'b0;
    chk("R4 coincident event kept", rd_data, 8'h11);

    // R7: pins ignored in loopback
    cts_n = 1'b0; dsr_n = 1'b0; cycn(STG + 3);
    chk("R7 pins ignored", rd_data, 8'h11);
    cts_n = 1'b1; dsr_n = 1'b1; cycn(STG + 2);

    // R8: permit follows CTS only at boundaries
    loopback = 1'b0; mcr_rts = 1'b0; cycn(2);
    rd_stb = 1'b1; cyc(); rd_stb = 1'b0;
    autocts_en = 1'b1; tx_boundary = 1'b1; cts_n = 1'b0; cycn(STG + 3);
    chk("R8 permit active", {7'b0, tx_permit}, 8'h01);
    tx_boundary = 1'b0; cts_n = 1'b1; cycn(STG + 3);
    chk("R8 held mid-frame", {7'b0, tx_permit}, 8'h01);
    tx_boundary = 1'b1; cyc();
    chk("R8 stop at boundary", {7'b0, tx_permit}, 8'h00);
    tx_boundary = 1'b0;

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 9) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(0, 9) == 0) ri_n  = ~ri_n;
      if ($urandom_range(0, 11) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(0, 59) == 0) loopback = ~loopback;
      if ($urandom_range(0, 99) == 0) autocts_en = ~autocts_en;
      if ($urandom_range(0, 5) == 0)
        {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} = 4'($urandom_range(0, 15));
      rd_stb      = ($urandom_range(0, 3) == 0);
      tx_boundary = ($urandom_range(0, 2) == 0);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule